// File: doc/BRIEF.md
# Prioritised Coherence Event Dispatcher

This block sits in front of the line state machine of a mid-level cache controller. Three message queues feed it. The first carries responses arriving from the outer level. The second carries requests that the outer level forwards to this cache. The third carries requests and recall replies from the inner cache. Each cycle the dispatcher picks one queue head. It turns that head into a single protocol event code and names the line address the event applies to. It also drives a pop or stall strobe back to every queue it looked at.

The tag lookup happens outside the block and arrives as inputs. These inputs are a hit flag, the line state, a free-way flag, and the address and state of the victim line. From them the dispatcher makes two decisions that change the event stream. An outer request that targets a line the inner cache still holds becomes a recall event, so the line is pulled back from the inner cache before the request is served. An inner request that misses when no way is free is redirected to the victim line, so that the victim is evicted or recalled first. The pop and stall strobes are combinational in the cycle of the decision. The chosen event is registered and appears one cycle later.

Top module: `evt_dispatch`

## Requirements
- R1: While `rst` is high, `q_pop` and `q_stall` are zero. After any clock edge with `rst` high, `ev_vld`, `ev_code`, `ev_src` and `ev_addr` are all zero.
- R2: Queue bit positions are 0 for outer responses, 1 for forwarded requests and 2 for inner requests, and that order is the fixed priority. At most one `q_pop` bit is set per cycle, and it belongs to the highest-priority valid queue that is not held. One clock edge after a pop, `ev_vld` is 1 and `ev_src` holds the popped queue's bit position. A cycle without a pop gives `ev_vld` = 0 one edge later.
- R3: A valid head with its hold input high, in a queue above the popped one (or when nothing pops), gets its `q_stall` bit and is not popped. The next lower queue is considered in the same cycle. Queues below the popped one get neither strobe.
- R4: Outer responses use kinds 0 (data), 1 (exclusive data), 2 (ack) and 3 (writeback ack), and the event goes to `rsp_addr`. Exclusive data gives event 12 and writeback ack gives event 17. Data gives event 13 when `rsp_from_peer` is set and `rsp_state` is 8 or 11. Otherwise data gives 14 if `rsp_pend_acks` equals `rsp_ack_cnt`, and 11 if not. Ack gives 16 if the two counts are equal and 15 if not.
- R5: Forwarded requests use kinds 0 (invalidate), 1 (exclusive read), 2 (upgrade) and 3 (shared read), and the event goes to `fwd_addr`. If `fwd_hit` is set and `fwd_state` is in the inner-presence set, the event is 6. Otherwise invalidate gives 10, exclusive read and upgrade both give 8, and shared read gives 9.
- R6: Inner kinds are 0 (shared read), 1 (exclusive read), 2 (upgrade) and 3 (writeback). When `inr_hit` or `inr_way_free` is set, they give events 0, 1, 1 and 2 in that order, on `inr_addr`.
- R7: Inner kind 4 (recall reply with data) gives event 3 and kind 5 (recall ack) gives event 4. Both go to `inr_addr`, whatever the lookup inputs say.
- R8: An inner request of kind 0 to 3 with `inr_hit` and `inr_way_free` both low targets `inr_vic_addr`. The event is 5 if `inr_vic_state` is in the inner-presence set and 7 if it is not.
- R9: Line-state codes 0 to 18 are defined. The inner-presence set is exactly codes 2, 4, 6, 14, 15, 16 and 18. Codes 17 and 8 (pending read) are outside it, and so is every other code.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rsp_vld | input | 1 | Outer response queue has a head |
| rsp_hold | input | 1 | Response head must wait (line busy) |
| rsp_kind | input | 2 | Response kind |
| rsp_addr | input | AW | Response line address |
| rsp_state | input | 5 | Current state of the response line |
| rsp_from_peer | input | 1 | Response data came from a peer cache |
| rsp_ack_cnt | input | CW | Ack count carried by the response |
| rsp_pend_acks | input | CW | Acks the open transaction still expects |
| fwd_vld | input | 1 | Forwarded request queue has a head |
| fwd_hold | input | 1 | Forwarded head must wait |
| fwd_kind | input | 2 | Forwarded request kind |
| fwd_addr | input | AW | Forwarded request line address |
| fwd_hit | input | 1 | Line is present in this cache |
| fwd_state | input | 5 | State of the forwarded line |
| inr_vld | input | 1 | Inner queue has a head |
| inr_hold | input | 1 | Inner head must wait |
| inr_kind | input | 3 | Inner message kind |
| inr_addr | input | AW | Inner request line address |
| inr_hit | input | 1 | Requested line is present |
| inr_way_free | input | 1 | A free way exists in the set |
| inr_vic_addr | input | AW | Victim line chosen by the probe |
| inr_vic_state | input | 5 | State of the victim line |
| q_pop | output | 3 | Per-queue pop strobe, same cycle |
| q_stall | output | 3 | Per-queue stall strobe, same cycle |
| ev_vld | output | 1 | Registered event valid |
| ev_code | output | 5 | Registered event code |
| ev_src | output | 2 | Queue the event came from |
| ev_addr | output | AW | Line the event applies to |

## Verification
Random cycles drive all three queues together, with independent valid and hold bits and random kinds, states, counts and lookup flags. This separates a wrong priority or stall rule from a wrong decode, because every cycle's strobes and the next cycle's event are compared with a bench model. Directed cycles then cover the cases random stimulus hits only rarely. These are a chain of two held queues falling through to the inner queue, and a forwarded request on the one recall-pending state that is outside the presence set. They also include a hit flag that is low while the state is in the set, recall replies on a full set, and the three response outcomes that depend on the peer flag and on equal ack counts.

// File: rtl/evdisp_pkg.sv
package evdisp_pkg;

  localparam int NQ    = 3;
  localparam int SRC_W = 2;
  localparam int ST_W  = 5;
  localparam int EV_W  = 5;

  typedef enum logic [1:0] {
    RSP_DATA = 2'd0, RSP_DATA_EXCL = 2'd1, RSP_ACK = 2'd2, RSP_WB_ACK = 2'd3
  } rsp_kind_e;

  typedef enum logic [1:0] {
    FWD_INV = 2'd0, FWD_RD_EX = 2'd1, FWD_UPG = 2'd2, FWD_RD_SH = 2'd3
  } fwd_kind_e;

  typedef enum logic [2:0] {
    INR_RD_SH = 3'd0, INR_RD_EX = 3'd1, INR_UPG = 3'd2, INR_WB = 3'd3,
    INR_INV_DATA = 3'd4, INR_INV_ACK = 3'd5
  } inr_kind_e;

  typedef enum logic [ST_W-1:0] {
    ST_ABSENT      = 5'd0,  ST_IDLE        = 5'd1,  ST_SH_IN      = 5'd2,
    ST_SH          = 5'd3,  ST_EX_IN       = 5'd4,  ST_EX         = 5'd5,
    ST_MOD_IN      = 5'd6,  ST_MOD         = 5'd7,  ST_RD_PEND    = 5'd8,
    ST_WR_PEND     = 5'd9,  ST_UPG_PEND    = 5'd10, ST_RD_PEND_INV = 5'd11,
    ST_WB_PEND     = 5'd12, ST_WB_SINK     = 5'd13, ST_SH_RECALL  = 5'd14,
    ST_EX_RECALL   = 5'd15, ST_MOD_RECALL  = 5'd16, ST_MODX_RECALL = 5'd17,
    ST_UPG_RECALL  = 5'd18
  } line_st_e;

  typedef enum logic [EV_W-1:0] {
    EV_LOAD = 5'd0, EV_STORE = 5'd1, EV_WRBACK = 5'd2, EV_INNER_DATA_ACK = 5'd3,
    EV_INNER_ACK = 5'd4, EV_RECALL_OWN = 5'd5, EV_RECALL_OTHER = 5'd6,
    EV_REPLACE = 5'd7, EV_FWD_EXCL = 5'd8, EV_FWD_SHARED = 5'd9, EV_INVAL = 5'd10,
    EV_DATA = 5'd11, EV_DATA_EXCL = 5'd12, EV_DATA_PEER = 5'd13,
    EV_DATA_ALL = 5'd14, EV_ACK = 5'd15, EV_ACK_ALL = 5'd16, EV_WB_DONE = 5'd17
  } ev_e;

  function automatic logic inner_present(input logic [ST_W-1:0] st);
    case (line_st_e'(st))
      ST_SH_IN, ST_EX_IN, ST_MOD_IN,
      ST_SH_RECALL, ST_EX_RECALL, ST_MOD_RECALL, ST_UPG_RECALL: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/evd_arb.sv
module evd_arb #(
  parameter int NQ = 3,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NQ-1:0] req,
  input  logic [NQ-1:0] hold,
  output logic [NQ-1:0] pop,
  output logic [NQ-1:0] stall,
  output logic [SW-1:0] sel
);

  // reach[i]: no higher-priority queue was popped this cycle
  logic [NQ-1:0] reach;
  assign reach[0] = 1'b1;

  for (genvar g = 0; g < NQ; g++) begin : g_q
    assign pop[g]   = reach[g] & req[g] & ~hold[g];
    assign stall[g] = reach[g] & req[g] & hold[g];
    if (g < NQ - 1) begin : g_nx
      assign reach[g+1] = reach[g] & ~(req[g] & ~hold[g]);
    end

    AST_STALL_ONLY_HELD: assert property (@(posedge clk) disable iff (rst)
      stall[g] |-> (hold[g] && req[g])); // R3
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < NQ; i++) begin
      if (pop[i]) sel = SW'(i);
    end
  end

  AST_ONE_POP: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pop)); // R2
  AST_STALL_NOT_POP: assert property (@(posedge clk) disable iff (rst)
    (stall & pop) == '0); // R3

endmodule

// File: rtl/evd_rsp_dec.sv
module evd_rsp_dec
  import evdisp_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic [1:0]      kind,
  input  logic [ST_W-1:0] state,
  input  logic            from_peer,
  input  logic [CW-1:0]   ack_cnt,
  input  logic [CW-1:0]   pend_acks,
  output logic [EV_W-1:0] ev
);

  logic last_ack;
  logic read_open;

  assign last_ack  = (pend_acks == ack_cnt);
  assign read_open = (line_st_e'(state) == ST_RD_PEND) ||
                     (line_st_e'(state) == ST_RD_PEND_INV);

  always_comb begin
    case (rsp_kind_e'(kind))
      RSP_DATA_EXCL: ev = EV_DATA_EXCL;
      RSP_DATA: begin
        if (read_open && from_peer) ev = EV_DATA_PEER;
        else if (last_ack)          ev = EV_DATA_ALL;
        else                        ev = EV_DATA;
      end
      RSP_ACK:  ev = last_ack ? EV_ACK_ALL : EV_ACK;
      default:  ev = EV_WB_DONE;
    endcase
  end

endmodule

// File: rtl/evd_fwd_dec.sv
module evd_fwd_dec
  import evdisp_pkg::*;
(
  input  logic [1:0]      kind,
  input  logic            hit,
  input  logic [ST_W-1:0] state,
  output logic [EV_W-1:0] ev
);

  logic need_recall;
  assign need_recall = hit && inner_present(state);

  always_comb begin
    if (need_recall) begin
      ev = EV_RECALL_OTHER;
    end else begin
      case (fwd_kind_e'(kind))
        FWD_INV:            ev = EV_INVAL;
        FWD_RD_EX, FWD_UPG: ev = EV_FWD_EXCL;
        default:            ev = EV_FWD_SHARED;
      endcase
    end
  end

endmodule

// File: rtl/evd_inr_dec.sv
module evd_inr_dec
  import evdisp_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [2:0]      kind,
  input  logic [AW-1:0]   addr,
  input  logic            hit,
  input  logic            way_free,
  input  logic [AW-1:0]   vic_addr,
  input  logic [ST_W-1:0] vic_state,
  output logic [EV_W-1:0] ev,
  output logic [AW-1:0]   tgt
);

  logic recall_reply;
  logic has_room;

  assign recall_reply = (inr_kind_e'(kind) == INR_INV_DATA) ||
                        (inr_kind_e'(kind) == INR_INV_ACK);
  assign has_room     = hit || way_free;

  always_comb begin
    tgt = addr;
    if (recall_reply) begin
      ev = (inr_kind_e'(kind) == INR_INV_DATA) ? EV_INNER_DATA_ACK : EV_INNER_ACK;
    end else if (has_room) begin
      case (inr_kind_e'(kind))
        INR_RD_EX, INR_UPG: ev = EV_STORE;
        INR_WB:             ev = EV_WRBACK;
        default:            ev = EV_LOAD;
      endcase
    end else begin
      tgt = vic_addr;
      ev  = inner_present(vic_state) ? EV_RECALL_OWN : EV_REPLACE;
    end
  end

endmodule

// File: rtl/evt_dispatch.sv
module evt_dispatch
  import evdisp_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rsp_vld,
  input  logic          rsp_hold,
  input  logic [1:0]    rsp_kind,
  input  logic [AW-1:0] rsp_addr,
  input  logic [4:0]    rsp_state,
  input  logic          rsp_from_peer,
  input  logic [CW-1:0] rsp_ack_cnt,
  input  logic [CW-1:0] rsp_pend_acks,
  input  logic          fwd_vld,
  input  logic          fwd_hold,
  input  logic [1:0]    fwd_kind,
  input  logic [AW-1:0] fwd_addr,
  input  logic          fwd_hit,
  input  logic [4:0]    fwd_state,
  input  logic          inr_vld,
  input  logic          inr_hold,
  input  logic [2:0]    inr_kind,
  input  logic [AW-1:0] inr_addr,
  input  logic          inr_hit,
  input  logic          inr_way_free,
  input  logic [AW-1:0] inr_vic_addr,
  input  logic [4:0]    inr_vic_state,
  output logic [2:0]    q_pop,
  output logic [2:0]    q_stall,
  output logic          ev_vld,
  output logic [4:0]    ev_code,
  output logic [1:0]    ev_src,
  output logic [AW-1:0] ev_addr
);

  localparam int SW = SRC_W;

  logic [NQ-1:0]   req, hold, pop, stall;
  logic [SW-1:0]   sel;
  logic [EV_W-1:0] rsp_ev, fwd_ev, inr_ev;
  logic [AW-1:0]   inr_tgt;
  logic [EV_W-1:0] nxt_code;
  logic [AW-1:0]   nxt_addr;

  assign req  = {inr_vld, fwd_vld, rsp_vld} & {NQ{~rst}};
  assign hold = {inr_hold, fwd_hold, rsp_hold};

  evd_arb #(.NQ(NQ), .SW(SW)) u_arb (
    .clk(clk), .rst(rst), .req(req), .hold(hold),
    .pop(pop), .stall(stall), .sel(sel)
  );

  evd_rsp_dec #(.CW(CW)) u_rsp (
    .kind(rsp_kind), .state(rsp_state), .from_peer(rsp_from_peer),
    .ack_cnt(rsp_ack_cnt), .pend_acks(rsp_pend_acks), .ev(rsp_ev)
  );

  evd_fwd_dec u_fwd (
    .kind(fwd_kind), .hit(fwd_hit), .state(fwd_state), .ev(fwd_ev)
  );

  evd_inr_dec #(.AW(AW)) u_inr (
    .kind(inr_kind), .addr(inr_addr), .hit(inr_hit), .way_free(inr_way_free),
    .vic_addr(inr_vic_addr), .vic_state(inr_vic_state), .ev(inr_ev), .tgt(inr_tgt)
  );

  always_comb begin
    case (sel)
      SW'(0):  begin nxt_code = rsp_ev; nxt_addr = rsp_addr; end
      SW'(1):  begin nxt_code = fwd_ev; nxt_addr = fwd_addr; end
      default: begin nxt_code = inr_ev; nxt_addr = inr_tgt;  end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_vld  <= 1'b0;
      ev_code <= '0;
      ev_src  <= '0;
      ev_addr <= '0;
    end else begin
      ev_vld <= |pop;
      if (|pop) begin
        ev_code <= nxt_code;
        ev_src  <= sel;
        ev_addr <= nxt_addr;
      end
    end
  end

  assign q_pop   = pop;
  assign q_stall = stall;

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!ev_vld && ev_addr == '0)); // R1
  AST_TOP_WINS: assert property (@(posedge clk) disable iff (rst)
    (rsp_vld && !rsp_hold) |-> (q_pop == 3'b001)); // R2
  AST_EV_AFTER_POP: assert property (@(posedge clk) disable iff (rst)
    (|q_pop) |=> ev_vld); // R2
  AST_NO_EV_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(|q_pop) |=> !ev_vld); // R2
  AST_WB_DONE: assert property (@(posedge clk) disable iff (rst)
    (q_pop[0] && rsp_kind == 2'd3) |=> (ev_code == EV_WB_DONE)); // R4
  AST_RECALL_OTHER: assert property (@(posedge clk) disable iff (rst)
    (q_pop[1] && fwd_hit && inner_present(fwd_state)) |=> (ev_code == EV_RECALL_OTHER)); // R5
  AST_WRBACK_ROOM: assert property (@(posedge clk) disable iff (rst)
    (q_pop[2] && inr_kind == 3'd3 && (inr_hit || inr_way_free)) |=> (ev_code == EV_WRBACK)); // R6
  AST_REPLY_OWN: assert property (@(posedge clk) disable iff (rst)
    (q_pop[2] && inr_kind >= 3'd4) |=> (ev_addr == $past(inr_addr))); // R7
  AST_VICTIM_ADDR: assert property (@(posedge clk) disable iff (rst)
    (q_pop[2] && inr_kind < 3'd4 && !inr_hit && !inr_way_free)
      |=> (ev_addr == $past(inr_vic_addr))); // R8

endmodule

// File: tb/sim_evt_dispatch.sv
`timescale 1ns/1ps
module sim_evt_dispatch;

  localparam int AW = 16;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rsp_vld = 0, rsp_hold = 0, rsp_from_peer = 0;
  logic [1:0] rsp_kind = 0;
  logic [AW-1:0] rsp_addr = 0;
  logic [4:0] rsp_state = 0;
  logic [CW-1:0] rsp_ack_cnt = 0, rsp_pend_acks = 0;
  logic fwd_vld = 0, fwd_hold = 0, fwd_hit = 0;
  logic [1:0] fwd_kind = 0;
  logic [AW-1:0] fwd_addr = 0;
  logic [4:0] fwd_state = 0;
  logic inr_vld = 0, inr_hold = 0, inr_hit = 0, inr_way_free = 0;
  logic [2:0] inr_kind = 0;
  logic [AW-1:0] inr_addr = 0, inr_vic_addr = 0;
  logic [4:0] inr_vic_state = 0;
  logic [2:0] q_pop, q_stall;
  logic ev_vld;
  logic [4:0] ev_code;
  logic [1:0] ev_src;
  logic [AW-1:0] ev_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  evt_dispatch #(.AW(AW), .CW(CW)) u0 (
    .clk(clk), .rst(rst),
    .rsp_vld(rsp_vld), .rsp_hold(rsp_hold), .rsp_kind(rsp_kind), .rsp_addr(rsp_addr),
    .rsp_state(rsp_state), .rsp_from_peer(rsp_from_peer), .rsp_ack_cnt(rsp_ack_cnt),
    .rsp_pend_acks(rsp_pend_acks),
    .fwd_vld(fwd_vld), .fwd_hold(fwd_hold), .fwd_kind(fwd_kind), .fwd_addr(fwd_addr),
    .fwd_hit(fwd_hit), .fwd_state(fwd_state),
    .inr_vld(inr_vld), .inr_hold(inr_hold), .inr_kind(inr_kind), .inr_addr(inr_addr),
    .inr_hit(inr_hit), .inr_way_free(inr_way_free), .inr_vic_addr(inr_vic_addr),
    .inr_vic_state(inr_vic_state),
    .q_pop(q_pop), .q_stall(q_stall), .ev_vld(ev_vld), .ev_code(ev_code),
    .ev_src(ev_src), .ev_addr(ev_addr)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // R9 presence set
  function automatic bit in_set(input logic [4:0] s);
    return (s == 2 || s == 4 || s == 6 || s == 14 || s == 15 || s == 16 || s == 18);
  endfunction

  function automatic int exp_rsp();
    if (rsp_kind == 1) return 12;
    if (rsp_kind == 3) return 17;
    if (rsp_kind == 0) begin
      if (rsp_from_peer && (rsp_state == 8 || rsp_state == 11)) return 13;
      return (rsp_pend_acks == rsp_ack_cnt) ? 14 : 11;
    end
    return (rsp_pend_acks == rsp_ack_cnt) ? 16 : 15;
  endfunction

  function automatic int exp_fwd();
    if (fwd_hit && in_set(fwd_state)) return 6;
    if (fwd_kind == 0) return 10;
    if (fwd_kind == 3) return 9;
    return 8;
  endfunction

  function automatic int exp_inr();
    if (inr_kind == 4) return 3;
    if (inr_kind == 5) return 4;
    if (inr_hit || inr_way_free) begin
      if (inr_kind == 0) return 0;
      if (inr_kind == 3) return 2;
      return 1;
    end
    return in_set(inr_vic_state) ? 5 : 7;
  endfunction

  // One cycle: inputs already driven after a falling edge.
  task automatic run_cycle();
    logic [2:0] e_pop, e_stall;
    bit reach;
    int win;
    int e_code;
    logic [AW-1:0] e_addr;
    string tag;
    logic [2:0] vv, hh;
    vv = {inr_vld, fwd_vld, rsp_vld};
    hh = {inr_hold, fwd_hold, rsp_hold};
    e_pop = 0; e_stall = 0; reach = 1; win = -1;
    for (int i = 0; i < 3; i++) begin
      if (reach && vv[i]) begin
        if (hh[i]) e_stall[i] = 1'b1;
        else begin e_pop[i] = 1'b1; reach = 0; win = i; end
      end
    end
    e_code = 0; e_addr = 0; tag = "R2";
    if (win == 0) begin e_code = exp_rsp(); e_addr = rsp_addr; tag = "R4"; end
    else if (win == 1) begin e_code = exp_fwd(); e_addr = fwd_addr; tag = "R5"; end
    else if (win == 2) begin
      e_code = exp_inr();
      if (inr_kind >= 4) begin e_addr = inr_addr; tag = "R7"; end
      else if (inr_hit || inr_way_free) begin e_addr = inr_addr; tag = "R6"; end
      else begin e_addr = inr_vic_addr; tag = "R8"; end
    end
    #2;
    check(q_pop == e_pop, (hh & vv) != 0 ? "R3" : "R2", "q_pop", q_pop, e_pop);
    check(q_stall == e_stall, "R3", "q_stall", q_stall, e_stall);
    @(posedge clk);
    #1;
    check(ev_vld == (win >= 0), "R2", "ev_vld", ev_vld, win >= 0);
    if (win >= 0) begin
      check(ev_src == win[1:0], "R2", "ev_src", ev_src, win);
      check(ev_code == e_code[4:0], tag, "ev_code", ev_code, e_code);
      check(ev_addr == e_addr, tag, "ev_addr", ev_addr, e_addr);
    end
  endtask

  task automatic clear_all();
    rsp_vld = 0; rsp_hold = 0; fwd_vld = 0; fwd_hold = 0; inr_vld = 0; inr_hold = 0;
  endtask

  initial begin
    #(20 * 200000);
    check(1'b0, "WDOG", "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    // R1: reset with all queues offering work
    rsp_vld = 1; fwd_vld = 1; inr_vld = 1; rsp_addr = 16'h1111;
    repeat (3) @(posedge clk);
    #1;
    check(q_pop == 0, "R1", "q_pop in reset", q_pop, 0);
    check(q_stall == 0, "R1", "q_stall in reset", q_stall, 0);
    check(ev_vld == 0 && ev_code == 0 && ev_src == 0 && ev_addr == 0,
          "R1", "event regs in reset", {ev_vld, ev_code, ev_addr}, 0);
    @(negedge clk); rst = 0; clear_all();

    // R2: all three valid, responses win
    @(negedge clk);
    rsp_vld = 1; fwd_vld = 1; inr_vld = 1; rsp_kind = 3; rsp_addr = 16'h00A0;
    fwd_addr = 16'h00B0; inr_addr = 16'h00C0;
    run_cycle();
    // R3: held response, forwarded pops in same cycle
    @(negedge clk); rsp_hold = 1; fwd_kind = 1; fwd_hit = 1; fwd_state = 7;
    run_cycle();
    // R3: two held queues fall through to inner
    @(negedge clk); fwd_hold = 1; inr_kind = 3; inr_hit = 1;
    run_cycle();
    // R5: state 17 outside the set, shared read
    @(negedge clk); clear_all(); fwd_vld = 1; fwd_kind = 3; fwd_hit = 1; fwd_state = 17;
    run_cycle();
    // R5: line in set but not hit -> plain invalidate
    @(negedge clk); fwd_kind = 0; fwd_hit = 0; fwd_state = 2;
    run_cycle();
    // R5: upgrade on hit in set -> recall
    @(negedge clk); fwd_kind = 2; fwd_hit = 1; fwd_state = 18;
    run_cycle();
    // R8: full set, victim held by inner cache
    @(negedge clk); clear_all(); inr_vld = 1; inr_kind = 0; inr_hit = 0; inr_way_free = 0;
    inr_addr = 16'h1234; inr_vic_addr = 16'h9ABC; inr_vic_state = 16;
    run_cycle();
    // R8: victim not in inner cache
    @(negedge clk); inr_vic_state = 7; inr_kind = 2;
    run_cycle();
    // R7: recall replies ignore lookup
    @(negedge clk); inr_kind = 4;
    run_cycle();
    @(negedge clk); inr_kind = 5; inr_vic_state = 2;
    run_cycle();
    // R6: free way, exclusive read
    @(negedge clk); inr_kind = 1; inr_way_free = 1;
    run_cycle();
    // R4: peer data on pending read
    @(negedge clk); clear_all(); rsp_vld = 1; rsp_kind = 0; rsp_state = 11; rsp_from_peer = 1;
    rsp_ack_cnt = 2; rsp_pend_acks = 5;
    run_cycle();
    @(negedge clk); rsp_from_peer = 0; rsp_ack_cnt = 3; rsp_pend_acks = 3;
    run_cycle();
    @(negedge clk); rsp_kind = 2; rsp_state = 8; rsp_ack_cnt = 1; rsp_pend_acks = 2;
    run_cycle();
    @(negedge clk); rsp_kind = 1;
    run_cycle();
    // idle cycle: R2 no event
    @(negedge clk); clear_all();
    run_cycle();

    // random mix
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      rsp_vld = $urandom % 2; rsp_hold = ($urandom % 4) == 0;
      rsp_kind = $urandom; rsp_addr = $urandom; rsp_state = $urandom % 19;
      rsp_from_peer = $urandom; rsp_ack_cnt = $urandom % 3; rsp_pend_acks = $urandom % 3;
      fwd_vld = $urandom % 2; fwd_hold = ($urandom % 4) == 0;
      fwd_kind = $urandom; fwd_addr = $urandom; fwd_hit = $urandom; fwd_state = $urandom % 19;
      inr_vld = $urandom % 2; inr_hold = ($urandom % 4) == 0;
      inr_kind = $urandom % 6; inr_addr = $urandom; inr_hit = $urandom;
      inr_way_free = $urandom; inr_vic_addr = $urandom; inr_vic_state = $urandom % 19;
      run_cycle();
    end
    finish_run();
  end

endmodule